// File: doc/BRIEF.md
# NVM Configuration Autoload Sequencer

After reset, this block reads a few 16-bit words from a word-addressed nonvolatile memory. It uses them to set the PCI identity values and the power-management capability bits of a network function. The block first reads a signature word to find out whether the memory holds a valid image. If the signature is good, it reads the initialization control word. Two flags in that control word decide whether the subsystem identity pair is fetched and whether the vendor/device identity pair is fetched. Any word the block does not read keeps a fixed default.

The memory is reached through a request channel with valid/ready and a response channel with a valid strobe only. The request channel follows the usual back-pressure rule: once `rd_req_valid_o` is high, it and `rd_addr_o` stay unchanged until a cycle in which `rd_req_ready_i` is high, and that cycle is the handshake. The response channel has no ready signal, because the block always has room for the single read it has outstanding. When every required word has been captured, `done_o` goes high and stays high. The identity and capability outputs then hold until a reset or a `restart_i` pulse starts a new load.

Top module: `nvm_autoload`

## Requirements
- R1: While reset is held, `done_o` and `rd_req_valid_o` are low and all identity and capability outputs show their defaults. After reset is released, the sequence starts by itself.
- R2: The first read goes to word address 0x13. If bits 15:14 of that word are not 2'b10, no further reads are made, `done_o` rises, and every output keeps its default.
- R3: Requests follow a fixed order: 0x13, 0x0A, then 0x0B and 0x0C if enabled, then 0x0D and 0x0E if enabled. Valid and address hold stable while ready is low. At most one read is outstanding, and a new request starts only after the response strobe. A response strobe that arrives with no read outstanding is ignored.
- R4: Word 0x0A is the control word. When its bit 1 is 1, word 0x0B becomes the subsystem ID and word 0x0C the subsystem vendor ID. When bit 1 is 0, neither word is read and the values stay 16'h0000 and 16'h8086.
- R5: When control bit 0 is 1, word 0x0D becomes the device ID and word 0x0E the vendor ID. When bit 0 is 0, neither word is read and the parameter defaults `DEF_DEVICE_ID` and `DEF_VENDOR_ID` stay in place.
- R6: `pme_support_o` equals control bit 6.
- R7: `d3cold_wake_o` is high only when control bits 7 and 6 are both 1.
- R8: `apm_wake_o` equals control bit 2, and requests that MAC and PHY come up functional after power-up.
- R9: If the control word is not read, its default 16'h10C7 applies, so all three capability outputs are 1.
- R10: `done_o` goes high the cycle after the last needed response and stays high. While `done_o` is high, outputs and the read port stay unchanged. `revision_o` is always zero.
- R11: A one-cycle `restart_i` pulse while `done_o` is high restores all defaults and runs the whole sequence again. A pulse while a load is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Start a new load (honoured only when done) |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Memory accepts the request |
| rd_addr_o | output | ADDR_W | Word address of the request |
| rd_rsp_valid_i | input | 1 | Read data strobe |
| rd_rsp_data_i | input | 16 | Read data word |
| vendor_id_o | output | 16 | PCI vendor ID |
| device_id_o | output | 16 | PCI device ID |
| subsys_id_o | output | 16 | PCI subsystem ID |
| subsys_vendor_id_o | output | 16 | PCI subsystem vendor ID |
| revision_o | output | REV_W | Device revision, constant zero |
| pme_support_o | output | 1 | PME support advertised |
| d3cold_wake_o | output | 1 | Wake from D3cold advertised |
| apm_wake_o | output | 1 | Bring MAC and PHY up functional after power-up |
| done_o | output | 1 | Load finished, held high |

## Verification
The checker assumes the memory side is well behaved. It raises the response strobe exactly once for each accepted request and never while a read it owes is still pending. Under that assumption, the outstanding-read property is a statement about the block and not about the memory.

The bench's memory model keeps within this assumption. It varies the response latency and the ready pattern, and it injects stray strobes only in cycles when no read is outstanding. This exercises the rule that unsolicited strobes are ignored without violating the single-response assumption.

// File: rtl/nvm_autoload_pkg.sv
package nvm_autoload_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} state_e;

  // Fetch steps in fixed order; every step after STEP_SIG owns one capture slot
  typedef enum logic [2:0] {
    STEP_SIG, STEP_CTL, STEP_SSID, STEP_SSVID, STEP_DEVID, STEP_VENID
  } step_e;

  localparam int NUM_SLOTS = 5;

  localparam logic [1:0]  SIG_VALID   = 2'b10;
  localparam logic [15:0] CTL_DEFAULT = 16'h10C7;
  localparam logic [15:0] SSID_DEF    = 16'h0000;
  localparam logic [15:0] SSVID_DEF   = 16'h8086;

  localparam int CTL_LOAD_VD  = 0;
  localparam int CTL_LOAD_SS  = 1;
  localparam int CTL_APM      = 2;
  localparam int CTL_PM       = 6;
  localparam int CTL_AUXPWR   = 7;

  function automatic logic [7:0] step_word(step_e s);
    case (s)
      STEP_SIG:   return 8'h13;
      STEP_CTL:   return 8'h0A;
      STEP_SSID:  return 8'h0B;
      STEP_SSVID: return 8'h0C;
      STEP_DEVID: return 8'h0D;
      default:    return 8'h0E;
    endcase
  endfunction

  function automatic logic [15:0] slot_default(int idx, logic [15:0] def_dev,
                                               logic [15:0] def_ven);
    case (idx)
      0:       return CTL_DEFAULT;
      1:       return SSID_DEF;
      2:       return SSVID_DEF;
      3:       return def_dev;
      default: return def_ven;
    endcase
  endfunction

endpackage

// File: rtl/nvm_autoload_seq.sv
module nvm_autoload_seq
  import nvm_autoload_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic [15:0]       rsp_data_i,
  output logic              cap_en_o,
  output step_e             cap_step_o,
  output logic              load_def_o,
  output logic              done_o
);

  state_e state_q;
  step_e  step_q;
  logic   want_vd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      step_q    <= STEP_SIG;
      want_vd_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_q <= ST_REQ;
          step_q  <= STEP_SIG;
        end
        ST_REQ: if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          state_q <= ST_REQ;
          case (step_q)
            STEP_SIG:
              if (rsp_data_i[15:14] == SIG_VALID) step_q <= STEP_CTL;
              else                                state_q <= ST_DONE;
            STEP_CTL: begin
              want_vd_q <= rsp_data_i[CTL_LOAD_VD];
              if (rsp_data_i[CTL_LOAD_SS])      step_q <= STEP_SSID;
              else if (rsp_data_i[CTL_LOAD_VD]) step_q <= STEP_DEVID;
              else                              state_q <= ST_DONE;
            end
            STEP_SSID:  step_q <= STEP_SSVID;
            STEP_SSVID:
              if (want_vd_q) step_q <= STEP_DEVID;
              else           state_q <= ST_DONE;
            STEP_DEVID: step_q <= STEP_VENID;
            default:    state_q <= ST_DONE;
          endcase
        end
        default: if (restart_i) state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_REQ);
  assign req_addr_o  = ADDR_W'(step_word(step_q));
  assign cap_en_o    = (state_q == ST_WAIT) && rsp_valid_i;
  assign cap_step_o  = step_q;
  assign load_def_o  = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

endmodule

// File: rtl/nvm_autoload_regs.sv
module nvm_autoload_regs
  import nvm_autoload_pkg::*;
#(
  parameter logic [15:0] DEF_VENDOR_ID = 16'h1AB0,
  parameter logic [15:0] DEF_DEVICE_ID = 16'h0C42
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_def_i,
  input  logic        cap_en_i,
  input  step_e       cap_step_i,
  input  logic [15:0] cap_data_i,
  output logic [15:0] ctl_o,
  output logic [15:0] ssid_o,
  output logic [15:0] ssvid_o,
  output logic [15:0] devid_o,
  output logic [15:0] venid_o
);

  logic [15:0] slot [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [15:0] DEF = slot_default(g, DEF_DEVICE_ID, DEF_VENDOR_ID);
    logic [15:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      q <= DEF;
      else if (load_def_i)                             q <= DEF;
      else if (cap_en_i && (int'(cap_step_i) == g + 1)) q <= cap_data_i;
    end
    assign slot[g] = q;
  end

  assign ctl_o   = slot[0];
  assign ssid_o  = slot[1];
  assign ssvid_o = slot[2];
  assign devid_o = slot[3];
  assign venid_o = slot[4];

endmodule

// File: rtl/nvm_autoload_caps.sv
module nvm_autoload_caps
  import nvm_autoload_pkg::*;
(
  input  logic [15:0] ctl_i,
  output logic        pme_o,
  output logic        d3cold_o,
  output logic        apm_o
);

  assign pme_o    = ctl_i[CTL_PM];
  assign d3cold_o = ctl_i[CTL_PM] & ctl_i[CTL_AUXPWR];
  assign apm_o    = ctl_i[CTL_APM];

endmodule

// File: rtl/nvm_autoload.sv
module nvm_autoload
  import nvm_autoload_pkg::*;
#(
  parameter int          ADDR_W        = 8,
  parameter int          REV_W         = 8,
  parameter logic [15:0] DEF_VENDOR_ID = 16'h1AB0,
  parameter logic [15:0] DEF_DEVICE_ID = 16'h0C42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_rsp_valid_i,
  input  logic [15:0]       rd_rsp_data_i,
  output logic [15:0]       vendor_id_o,
  output logic [15:0]       device_id_o,
  output logic [15:0]       subsys_id_o,
  output logic [15:0]       subsys_vendor_id_o,
  output logic [REV_W-1:0]  revision_o,
  output logic              pme_support_o,
  output logic              d3cold_wake_o,
  output logic              apm_wake_o,
  output logic              done_o
);

  logic        cap_en, load_def;
  step_e       cap_step;
  logic [15:0] ctl;

  nvm_autoload_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_i),
    .req_valid_o(rd_req_valid_o), .req_ready_i(rd_req_ready_i),
    .req_addr_o(rd_addr_o), .rsp_valid_i(rd_rsp_valid_i),
    .rsp_data_i(rd_rsp_data_i), .cap_en_o(cap_en), .cap_step_o(cap_step),
    .load_def_o(load_def), .done_o(done_o)
  );

  nvm_autoload_regs #(
    .DEF_VENDOR_ID(DEF_VENDOR_ID), .DEF_DEVICE_ID(DEF_DEVICE_ID)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .load_def_i(load_def), .cap_en_i(cap_en),
    .cap_step_i(cap_step), .cap_data_i(rd_rsp_data_i), .ctl_o(ctl),
    .ssid_o(subsys_id_o), .ssvid_o(subsys_vendor_id_o),
    .devid_o(device_id_o), .venid_o(vendor_id_o)
  );

  nvm_autoload_caps u_caps (
    .ctl_i(ctl), .pme_o(pme_support_o), .d3cold_o(d3cold_wake_o),
    .apm_o(apm_wake_o)
  );

  assign revision_o = '0;

endmodule

// File: rtl/nvm_autoload_chk.sv
module nvm_autoload_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart_i,
  input logic              rd_req_valid_o,
  input logic              rd_req_ready_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_rsp_valid_i,
  input logic [15:0]       vendor_id_o,
  input logic [15:0]       device_id_o,
  input logic [15:0]       subsys_id_o,
  input logic [15:0]       subsys_vendor_id_o,
  input logic              pme_support_o,
  input logic              d3cold_wake_o,
  input logic              done_o
);

  logic outstanding_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               outstanding_q <= 1'b0;
    else if (rd_req_valid_o && rd_req_ready_i) outstanding_q <= 1'b1;
    else if (rd_rsp_valid_i)                  outstanding_q <= 1'b0;
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_addr_o));

  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding_q |-> !rd_req_valid_o);

  assert_d3cold_needs_pme_R7: assert property (@(posedge clk) disable iff (!rst_n)
    d3cold_wake_o |-> pme_support_o);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !restart_i |=> done_o);

  assert_quiet_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_valid_o);

  assert_hold_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && $past(done_o) |-> $stable(vendor_id_o) && $stable(device_id_o) &&
      $stable(subsys_id_o) && $stable(subsys_vendor_id_o));

endmodule

bind nvm_autoload nvm_autoload_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart_i(restart_i),
  .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i),
  .rd_addr_o(rd_addr_o), .rd_rsp_valid_i(rd_rsp_valid_i),
  .vendor_id_o(vendor_id_o), .device_id_o(device_id_o),
  .subsys_id_o(subsys_id_o), .subsys_vendor_id_o(subsys_vendor_id_o),
  .pme_support_o(pme_support_o), .d3cold_wake_o(d3cold_wake_o),
  .done_o(done_o)
);

// File: tb/nvm_autoload_tb.sv
`timescale 1ns/1ps
module nvm_autoload_tb;

  localparam logic [15:0] DVEN = 16'h1AB0;
  localparam logic [15:0] DDEV = 16'h0C42;
  localparam int NV = 7;
  // columns: word 13h, 0Ah, 0Bh, 0Ch, 0Dh, 0Eh
  localparam logic [15:0] VEC [NV][6] = '{
    '{16'h8000, 16'h10C7, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0},
    '{16'h4000, 16'h10C7, 16'h1111, 16'h2222, 16'h3333, 16'h4444},
    '{16'hBFFF, 16'h1040, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD},
    '{16'h8123, 16'h1082, 16'h0101, 16'h0202, 16'h0303, 16'h0404},
    '{16'h8000, 16'h10C5, 16'h0F0F, 16'hF0F0, 16'h5A5A, 16'hA5A5},
    '{16'hC000, 16'h0000, 16'h7777, 16'h8888, 16'h9999, 16'hEEEE},
    '{16'h9000, 16'h0000, 16'h1357, 16'h2468, 16'hFACE, 16'hBEEF}
  };

  logic clk = 0, rst_n = 0, restart = 0;
  logic rd_req_valid, rd_req_ready = 0, rd_rsp_valid = 0;
  logic [7:0]  rd_addr;
  logic [15:0] rd_rsp_data = 0;
  logic [15:0] vendor_id, device_id, subsys_id, subsys_vendor_id;
  logic [7:0]  revision;
  logic pme, d3cold, apm, done;

  always #2.5 clk = ~clk;

  nvm_autoload u_dut (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .rd_req_valid_o(rd_req_valid), .rd_req_ready_i(rd_req_ready),
    .rd_addr_o(rd_addr), .rd_rsp_valid_i(rd_rsp_valid),
    .rd_rsp_data_i(rd_rsp_data), .vendor_id_o(vendor_id),
    .device_id_o(device_id), .subsys_id_o(subsys_id),
    .subsys_vendor_id_o(subsys_vendor_id), .revision_o(revision),
    .pme_support_o(pme), .d3cold_wake_o(d3cold), .apm_wake_o(apm),
    .done_o(done)
  );

  int tests = 0, fails = 0;
  logic [15:0] mem [32];
  logic [7:0]  alog [16];
  int nreads = 0;
  int cyc = 0;
  logic stall = 0, junk_en = 1;
  logic finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory model: varied latency, gaps in ready, stray strobes when idle
  initial begin
    logic hs, pend;
    logic [7:0] a_s, paddr;
    int cnt;
    pend = 0; cnt = 0; paddr = 0;
    forever begin
      @(negedge clk);
      hs  = rd_req_valid && rd_req_ready;
      a_s = rd_addr;
      @(posedge clk); #1;
      cyc++;
      rd_rsp_valid = 0;
      if (hs) begin
        if (nreads < 16) alog[nreads] = a_s;
        nreads++;
        pend = 1; paddr = a_s; cnt = cyc % 4;
      end else if (pend) begin
        if (cnt == 0) begin
          rd_rsp_valid = 1; rd_rsp_data = mem[paddr[4:0]]; pend = 0;
        end else cnt--;
      end else if (junk_en && (cyc % 7 == 3)) begin
        rd_rsp_valid = 1; rd_rsp_data = 16'hFFFF;
      end
      rd_req_ready = !stall && (cyc % 4 != 2);
    end
  end

  task automatic load_vec(int v);
    for (int i = 0; i < 32; i++) mem[i] = 16'hFFFF;
    mem[5'h13] = VEC[v][0]; mem[5'h0A] = VEC[v][1]; mem[5'h0B] = VEC[v][2];
    mem[5'h0C] = VEC[v][3]; mem[5'h0D] = VEC[v][4]; mem[5'h0E] = VEC[v][5];
  endtask

  task automatic pulse_restart();
    @(posedge clk); #1 restart = 1;
    @(posedge clk); #1 restart = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    if (!done) chk("R10 done timeout", 0, 1);
  endtask

  task automatic check_vec(int v);
    logic ok;
    logic [15:0] ctl;
    logic [7:0] ea [6];
    int en;
    ok  = (VEC[v][0][15:14] == 2'b10);
    ctl = ok ? VEC[v][1] : 16'h10C7;
    en = 1; ea[0] = 8'h13;
    if (ok) begin
      ea[en] = 8'h0A; en++;
      if (ctl[1]) begin ea[en] = 8'h0B; ea[en+1] = 8'h0C; en += 2; end
      if (ctl[0]) begin ea[en] = 8'h0D; ea[en+1] = 8'h0E; en += 2; end
    end
    @(negedge clk);
    chk("R2 R4 R5 read count", nreads, en);
    for (int i = 0; i < en && i < nreads; i++) chk("R3 read order", alog[i], ea[i]);
    chk("R4 subsys id", subsys_id, (ok && ctl[1]) ? VEC[v][2] : 16'h0000);
    chk("R4 subsys vendor", subsys_vendor_id, (ok && ctl[1]) ? VEC[v][3] : 16'h8086);
    chk("R5 device id", device_id, (ok && ctl[0]) ? VEC[v][4] : DDEV);
    chk("R5 vendor id", vendor_id, (ok && ctl[0]) ? VEC[v][5] : DVEN);
    chk("R6 pme", pme, ctl[6]);
    chk("R7 d3cold", d3cold, ctl[7] & ctl[6]);
    chk("R8 apm", apm, ctl[2]);
    if (!ok) chk("R9 default caps", {pme, d3cold, apm}, 3'b111);
    chk("R10 revision", revision, 0);
    chk("R10 done", done, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 16'hFFFF;
    load_vec(0);
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 done in reset", done, 0);
    chk("R1 valid in reset", rd_req_valid, 0);
    chk("R1 default ids", {vendor_id, device_id}, {DVEN, DDEV});
    chk("R1 default subsys", {subsys_id, subsys_vendor_id}, {16'h0000, 16'h8086});
    chk("R1 default caps R9", {pme, d3cold, apm}, 3'b111);
    @(posedge clk); #1 rst_n = 1;
    wait_done();
    check_vec(0);

    // Vector table walk via R11 restart
    for (int v = 1; v < NV; v++) begin
      load_vec(v);
      nreads = 0;
      pulse_restart();
      wait_done();
      check_vec(v);
    end

    // R11: restart during busy load is ignored; R3: stall holds address
    load_vec(0);
    nreads = 0;
    stall = 1;
    pulse_restart();
    repeat (4) @(negedge clk);
    chk("R3 stalled valid", rd_req_valid, 1);
    chk("R3 stalled addr R2", rd_addr, 8'h13);
    pulse_restart();
    stall = 0;
    wait_done();
    check_vec(0);

    // R10: outputs hold after done with restart idle
    repeat (20) @(negedge clk);
    chk("R10 hold vendor", vendor_id, 16'hDEF0);
    chk("R10 hold done", done, 1);
    chk("R10 no extra reads", nreads, 6);

    // R11: restart clears state back to defaults before capture
    load_vec(1);
    nreads = 0;
    pulse_restart();
    wait_done();
    check_vec(1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule